// File: doc/BRIEF.md
# One-Dimensional Sliding-Window Register Buffer

This block takes a stream of wide input beats and turns it into overlapping windows of consecutive elements for a parallel datapath. Each input beat carries four 32-bit elements. Each output window carries six consecutive elements, which is enough for a datapath to evaluate four 3-tap iterations side by side. Consecutive windows share two elements. The block keeps those shared elements in its own registers, so every element crosses the input interface exactly once.

The block holds two beats in an eight-slot element array. No window appears until both slots are filled, so even the first window has the full width. When a window is consumed, the array moves down by one beat and the next input beat fills the upper half. That beat then completes the following window, which starts four elements further on. A stall on the output freezes the window and closes the input. A last-beat flag ends a stream: the window that this flag completes is marked, and once that window is consumed the fill state starts again from empty.

Top module: `sliding_window_buf`

## Requirements
- R1: After a synchronous active-high reset, `win_valid` is 0 and `beat_ready` is 1.
- R2: No window is presented until two beats of a stream have been accepted. Element e of a beat sits in bits [32e+31:32e]. The first window holds stream elements 0 to 5, and window element k sits in bits [32k+31:32k].
- R3: When the first window is consumed and the third beat is accepted, the window holds stream elements 4 to 9. In general, window n holds elements 4n to 4n+5.
- R4: After the initial fill, each accepted beat produces exactly one window. A consumed window with no new beat leaves `win_valid` at 0. If a window is consumed and a beat is accepted in the same cycle, a new window is presented in the next cycle, so one window per cycle is sustained.
- R5: While `win_valid` is 1 and `win_ready` is 0, the window data and `win_last` stay stable, `win_valid` stays 1 and `beat_ready` is 0. `beat_ready` becomes 1 in the cycle in which `win_ready` is raised.
- R6: A beat offered during a stall is neither lost nor duplicated. Once the stall ends, the window after the stalled one starts exactly four elements later.
- R7: A beat accepted with `beat_last` = 1 that completes a window makes that window carry `win_last` = 1. After that window is consumed, the block again needs two beats before the next window.
- R8: A beat with `beat_last` = 1 accepted when no beat is held cannot complete a window. It is discarded without producing a window, and the next two beats form the first window.
- R9: `win_last` is 0 on every window that was not completed by a beat flagged last.
- R10: A reset in the middle of a stream discards the held beats. The block then needs two new beats before it presents a window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| beat_valid | input | 1 | Input beat is valid |
| beat_ready | output | 1 | Block can accept a beat |
| beat_data | input | 128 | Four packed elements; element 0 in the low bits |
| beat_last | input | 1 | This beat is the final beat of its stream |
| win_valid | output | 1 | Window is valid |
| win_ready | input | 1 | Datapath consumes the window |
| win_data | output | 192 | Six packed elements; element 0 in the low bits |
| win_last | output | 1 | Window was completed by the final beat of a stream |

## Verification
Four properties are checked on every cycle: the fill state stays within its three legal values, a stalled window keeps its data, flag and valid, the element array changes only when a shift or a load is requested, and a consumed last window is never followed directly by another window. Element order, the four-element slide, the lossless resumption after a stall, and the dropped lone last beat all depend on the contents of whole sequences. Only the bench's directed scenarios can show these, by comparing each window against element numbers computed from the stream.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;
  // Occupancy of the two-beat element array.
  typedef enum logic [1:0] {
    FILL_EMPTY = 2'd0,
    FILL_HALF  = 2'd1,
    FILL_FULL  = 2'd2
  } fill_e;
endpackage

// File: rtl/sbuf_fill_ctrl.sv
module sbuf_fill_ctrl
  import sbuf_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic in_last,
  input  logic out_ready,
  output logic in_ready,
  output logic out_valid,
  output logic out_last,
  output logic shift_en,
  output logic load_en,
  output logic load_hi
);
  fill_e st_q, st_pre, st_d;
  logic  last_q, last_d;
  logic  out_fire, in_fire;

  assign out_valid = (st_q == FILL_FULL);
  assign out_last  = last_q;
  assign out_fire  = out_valid && out_ready;
  assign in_ready  = (st_q != FILL_FULL) || out_ready;
  assign in_fire   = in_valid && in_ready;

  always_comb begin
    // occupancy once any consumed window has left
    st_pre = st_q;
    if (out_fire) st_pre = last_q ? FILL_EMPTY : FILL_HALF;
    st_d   = st_pre;
    last_d = last_q;
    if (out_fire) last_d = 1'b0;
    if (in_fire) begin
      if (st_pre == FILL_EMPTY) begin
        // a lone final beat cannot complete a window: drop it
        st_d = in_last ? FILL_EMPTY : FILL_HALF;
      end else begin
        st_d   = FILL_FULL;
        last_d = in_last;
      end
    end
  end

  assign shift_en = out_fire;
  assign load_en  = in_fire;
  assign load_hi  = (st_pre == FILL_HALF);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= FILL_EMPTY;
      last_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      last_q <= last_d;
    end
  end

  assert_fill_legal_R4: assert property (@(posedge clk) disable iff (rst)
    st_q inside {FILL_EMPTY, FILL_HALF, FILL_FULL});

  assert_valid_sticks_R5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> out_valid);

  assert_last_restarts_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && out_last) |=> !out_valid);
endmodule

// File: rtl/sbuf_elem_array.sv
module sbuf_elem_array #(
  parameter int ELEM_W = 32,
  parameter int BEAT_N = 4,
  parameter int WIN_N  = 6
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     shift_en,
  input  logic                     load_en,
  input  logic                     load_hi,
  input  logic [BEAT_N*ELEM_W-1:0] in_data,
  output logic [WIN_N*ELEM_W-1:0]  win_o
);
  localparam int REG_N = 2 * BEAT_N;

  logic [ELEM_W-1:0]       slot_q [REG_N];
  logic [REG_N*ELEM_W-1:0] slots_flat;

  for (genvar j = 0; j < REG_N; j++) begin : g_slot
    localparam int POS = j % BEAT_N;
    localparam bit HI  = (j >= BEAT_N);
    logic take;
    assign take = load_en && (load_hi == HI);
    if (j < BEAT_N) begin : g_lo
      always_ff @(posedge clk) begin
        if (rst)            slot_q[j] <= '0;
        else if (take)      slot_q[j] <= in_data[POS*ELEM_W +: ELEM_W];
        else if (shift_en)  slot_q[j] <= slot_q[j+BEAT_N];
      end
    end else begin : g_hi
      always_ff @(posedge clk) begin
        if (rst)            slot_q[j] <= '0;
        else if (take)      slot_q[j] <= in_data[POS*ELEM_W +: ELEM_W];
      end
    end
    assign slots_flat[j*ELEM_W +: ELEM_W] = slot_q[j];
  end

  assign win_o = slots_flat[WIN_N*ELEM_W-1:0];

  assert_array_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    !(shift_en || load_en) |=> $stable(slots_flat));
endmodule

// File: rtl/sliding_window_buf.sv
module sliding_window_buf #(
  parameter int ELEM_W = 32,
  parameter int BEAT_N = 4,
  parameter int TAPS   = 3
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            beat_valid,
  output logic                            beat_ready,
  input  logic [BEAT_N*ELEM_W-1:0]        beat_data,
  input  logic                            beat_last,
  output logic                            win_valid,
  input  logic                            win_ready,
  output logic [(BEAT_N+TAPS-1)*ELEM_W-1:0] win_data,
  output logic                            win_last
);
  localparam int WIN_N = BEAT_N + TAPS - 1;

  logic shift_en, load_en, load_hi;

  sbuf_fill_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (beat_valid),
    .in_last   (beat_last),
    .out_ready (win_ready),
    .in_ready  (beat_ready),
    .out_valid (win_valid),
    .out_last  (win_last),
    .shift_en  (shift_en),
    .load_en   (load_en),
    .load_hi   (load_hi)
  );

  sbuf_elem_array #(
    .ELEM_W (ELEM_W),
    .BEAT_N (BEAT_N),
    .WIN_N  (WIN_N)
  ) u_array (
    .clk      (clk),
    .rst      (rst),
    .shift_en (shift_en),
    .load_en  (load_en),
    .load_hi  (load_hi),
    .in_data  (beat_data),
    .win_o    (win_data)
  );

  assert_stall_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (win_valid && !win_ready) |=> ($stable(win_data) && $stable(win_last)));
endmodule

// File: tb/sliding_window_buf_test.sv
module sliding_window_buf_test;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int EW  = 32;
  localparam int BN  = 4;
  localparam int WN  = 6;
  localparam int BW  = BN * EW;
  localparam int WW  = WN * EW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          beat_valid = 1'b0;
  logic          beat_ready;
  logic [BW-1:0] beat_data = '0;
  logic          beat_last = 1'b0;
  logic          win_valid;
  logic          win_ready = 1'b0;
  logic [WW-1:0] win_data;
  logic          win_last;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  sliding_window_buf uut (
    .clk (clk), .rst (rst),
    .beat_valid (beat_valid), .beat_ready (beat_ready),
    .beat_data (beat_data), .beat_last (beat_last),
    .win_valid (win_valid), .win_ready (win_ready),
    .win_data (win_data), .win_last (win_last)
  );

  always #5 clk = ~clk;

  function automatic logic [EW-1:0] ev(int s, int i);
    return EW'(s * 65536 + i);
  endfunction

  function automatic logic [BW-1:0] beat(int s, int b);
    logic [BW-1:0] v;
    for (int e = 0; e < BN; e++) v[e*EW +: EW] = ev(s, b*BN + e);
    return v;
  endfunction

  function automatic logic [WW-1:0] win(int s, int first);
    logic [WW-1:0] v;
    for (int k = 0; k < WN; k++) v[k*EW +: EW] = ev(s, first + k);
    return v;
  endfunction

  task automatic chk(string req, string what, logic [WW-1:0] act, logic [WW-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic chk_win(string req, int s, int first, logic lst);
    chk(req, "win_valid", WW'(win_valid), WW'(1'b1));
    chk(req, "win_data", win_data, win(s, first));
    chk(req, "win_last", WW'(win_last), WW'(lst));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; beat_valid = 1'b0; win_ready = 1'b0; beat_last = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic push(int s, int b, logic lst);
    @(negedge clk);
    beat_data = beat(s, b); beat_last = lst; beat_valid = 1'b1;
    while (!beat_ready) @(negedge clk);
    @(posedge clk);
    #1 beat_valid = 1'b0; beat_last = 1'b0;
  endtask

  task automatic pop();
    @(negedge clk);
    win_ready = 1'b1;
    @(posedge clk);
    #1 win_ready = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1", "win_valid after reset", WW'(win_valid), WW'(1'b0));
    chk("R1", "beat_ready after reset", WW'(beat_ready), WW'(1'b1));
  endtask

  task automatic t_fill_slide();
    push(1, 0, 1'b0);
    chk("R2", "no window after one beat", WW'(win_valid), WW'(1'b0));
    push(1, 1, 1'b0);
    chk_win("R2", 1, 0, 1'b0);
    chk("R9", "last low on plain window", WW'(win_last), WW'(1'b0));
    pop();
    chk("R4", "no window without new beat", WW'(win_valid), WW'(1'b0));
    push(1, 2, 1'b0);
    chk_win("R3", 1, 4, 1'b0);
  endtask

  task automatic t_stall();
    pop();
    push(1, 3, 1'b0);
    chk_win("R3", 1, 8, 1'b0);
    @(negedge clk);
    beat_data = beat(1, 4); beat_valid = 1'b1; win_ready = 1'b0;
    for (int c = 0; c < 3; c++) begin
      @(posedge clk);
      #1;
      chk("R5", "beat_ready low in stall", WW'(beat_ready), WW'(1'b0));
      chk_win("R5", 1, 8, 1'b0);
    end
    @(negedge clk);
    win_ready = 1'b1;
    #1 chk("R5", "beat_ready on release", WW'(beat_ready), WW'(1'b1));
    @(posedge clk);
    #1 beat_valid = 1'b0; win_ready = 1'b0;
    chk_win("R6", 1, 12, 1'b0);
  endtask

  task automatic t_stream();
    for (int k = 5; k < 9; k++) begin
      @(negedge clk);
      beat_data = beat(1, k); beat_valid = 1'b1; win_ready = 1'b1;
      @(posedge clk);
      #1 chk_win("R4", 1, 4*(k-1), 1'b0);
    end
    beat_valid = 1'b0; win_ready = 1'b0;
  endtask

  task automatic t_last();
    pop();
    push(1, 9, 1'b1);
    chk_win("R7", 1, 32, 1'b1);
    pop();
    chk("R7", "no window after last", WW'(win_valid), WW'(1'b0));
    push(2, 0, 1'b0);
    chk("R7", "restart needs two beats", WW'(win_valid), WW'(1'b0));
    push(2, 1, 1'b0);
    chk_win("R7", 2, 0, 1'b0);
    chk("R9", "new stream last low", WW'(win_last), WW'(1'b0));
  endtask

  task automatic t_drop();
    do_reset();
    push(3, 0, 1'b1);
    chk("R8", "lone last beat no window", WW'(win_valid), WW'(1'b0));
    push(3, 1, 1'b0);
    chk("R8", "dropped beat not held", WW'(win_valid), WW'(1'b0));
    push(3, 2, 1'b0);
    chk_win("R8", 3, 4, 1'b0);
  endtask

  task automatic t_midreset();
    pop();
    do_reset();
    push(4, 0, 1'b0);
    chk("R10", "held beat cleared by reset", WW'(win_valid), WW'(1'b0));
    push(4, 1, 1'b0);
    chk_win("R10", 4, 0, 1'b0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_fill_slide();
    t_stall();
    t_stream();
    t_last();
    t_drop();
    t_midreset();
    finish_run();
  end

  initial begin
    #(200000 * 10);
    compared++;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule